// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block turns single-word requests from a synchronous client into the strobe sequences of an asynchronous DRAM with a multiplexed address bus. Each request carries a row, a column, a read/write flag and write data. The controller presents the row address, drops the row strobe, presents the column address and then drops the column strobe. A read returns its nibble with a one-cycle valid pulse. When the next request targets the row that is already open, the row strobe stays low and only the column strobe is cycled. This saves the precharge and row-open time on every access to that row.

Every timing limit is a parameter counted in controller clock cycles. These are row precharge, row-address hold, column strobe width, minimum row-active time and the page-mode ceiling on row-active time. Writes are always issued as early writes: the write strobe and the data drivers are active before the column strobe falls, and the output enable stays high. A separate refresh arbiter requests the memory through `ref_req`. The controller finishes any access in flight, closes the row, waits out precharge and answers with `ref_gnt`. It takes no client request until the arbiter withdraws its request.

The sequencer has eight states. IDLE: no row open. ROW_SET: row address set up. RAS_ACT: row strobe low, row address held. COL_SET: column address and write controls set up. CAS_LO: column strobe low. OPEN: row open, waiting. PRECH: row strobe high, precharge running. GRANT: memory handed to refresh. The transitions are:
- IDLE to ROW_SET when a request is accepted.
- IDLE to GRANT when refresh is requested.
- ROW_SET to RAS_ACT.
- RAS_ACT to COL_SET after the hold time.
- COL_SET to CAS_LO.
- CAS_LO to OPEN after the strobe width.
- OPEN to COL_SET on a row hit.
- OPEN to PRECH on a miss, on a refresh request, or when the page limit nears.
- PRECH to ROW_SET if a miss is pending, otherwise PRECH to IDLE.
- GRANT to IDLE when refresh is released.

Top module: `fpm_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, and `dram_dq_oe`, `rd_valid` and `ref_gnt` are 0.
- R2: The address bus holds the row value for the cycle before the row strobe falls and the column value for the cycle before the column strobe falls; neither value changes on the falling edge.
- R3: A read returns the nibble last written to the same row and column. `rd_valid` is high for exactly one cycle, in the cycle right after the column strobe has been low for T_CAS cycles.
- R4: A write drives `dram_we_n` low at least one cycle before the column strobe falls. `dram_dq_oe` is 1 only while `dram_we_n` is 0, and `dram_oe_n` is 1 whenever `dram_dq_oe` is 1.
- R5: Back-to-back requests to the open row cause no new row-strobe fall. The column strobe is low only while the row strobe is low.
- R6: A request to a different row raises the row strobe, and the strobe stays high at least T_RP cycles before it falls again.
- R7: The row strobe is never low for more than T_RASP_MAX consecutive cycles. A long run of same-row requests is split by closing and reopening the row.
- R8: Once low, the row strobe stays low at least T_RAS cycles.
- R9: `ref_gnt` rises only after the row strobe has been high for at least T_RP cycles. While it is high, both strobes are high and `req_ready` is 0. A refresh request and a client request arriving in the same idle cycle are resolved in favour of refresh.
- R10: Between two column-strobe pulses in the same open row, the column strobe is high for at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DQ_W | Read data |
| ref_req | input | 1 | Refresh arbiter wants the memory |
| ref_gnt | output | 1 | Memory released to the refresh arbiter |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed address |
| dram_dq_o | output | DQ_W | Data towards the memory |
| dram_dq_oe | output | 1 | Data pad drive enable |
| dram_dq_i | input | DQ_W | Data from the memory |

## Verification
A refresh request and a client request can meet in the same cycle. This happens both while a row is open and while the controller is idle. The bench provokes the idle case by raising `ref_req` and `req_valid` on the same falling clock edge. It then requires that `req_ready` stays low, that the grant appears with both strobes high after a full precharge, and that no row strobe falls while the grant is held. After the grant is released, the same request must complete and return the data written earlier. A scoreboard compares every read against a shadow memory of the writes. A pin-level memory model checks address setup, precharge length, row-active length and early-write ordering at every strobe edge.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SET,
        ST_RAS_ACT,
        ST_COL_SET,
        ST_CAS_LO,
        ST_OPEN,
        ST_PRECH,
        ST_GRANT
    } fpm_state_t;
endpackage

// File: rtl/fpm_delay_cnt.sv
module fpm_delay_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_ras_timer.sv
module fpm_ras_timer #(
    parameter int LIMIT = 20000,
    parameter int MIN   = 6,
    parameter int GUARD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_low,
    output logic min_met,
    output logic near_limit
);
    localparam int TW = $clog2(LIMIT + 2);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (ras_low) cnt_q <= cnt_q + 1'b1;
        else              cnt_q <= '0;
    end

    // cnt_q = low cycles already completed; closing now gives cnt_q+1 in total
    assign min_met    = (32'(cnt_q) + 1 >= MIN);
    assign near_limit = (32'(cnt_q) + GUARD > LIMIT);

    p_page_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ras_low |-> (32'(cnt_q) < LIMIT));
endmodule

// File: rtl/fpm_row_track.sv
module fpm_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_set) begin
            open_q <= 1'b1;
            row_q  <= open_row;
        end else if (close) begin
            open_q <= 1'b0;
        end
    end

    assign hit = open_q && (req_row == row_q);
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int DQ_W       = 4,
    parameter int T_RP       = 4,
    parameter int T_RAH      = 1,
    parameter int T_CAS      = 2,
    parameter int T_RAS      = 6,
    parameter int T_RASP_MAX = 20000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [DQ_W-1:0]  req_wdata,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data,
    input  logic             ref_req,
    output logic             ref_gnt,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic [DQ_W-1:0]  dram_dq_o,
    output logic             dram_dq_oe,
    input  logic [DQ_W-1:0]  dram_dq_i
);
    localparam int AW    = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int TMAX  = (T_RP > T_CAS) ? ((T_RP > T_RAH) ? T_RP : T_RAH)
                                          : ((T_CAS > T_RAH) ? T_CAS : T_RAH);
    localparam int CW    = $clog2(TMAX + 1);
    localparam int GUARD = T_CAS + 3;
    localparam int HW    = $clog2(T_RP + 2);

    fpm_state_t state_q, state_d;

    logic [ROW_W-1:0] row_q, row_d;
    logic [COL_W-1:0] col_q, col_d;
    logic             wr_q, wr_d;
    logic [DQ_W-1:0]  wd_q, wd_d;
    logic             pend_q, pend_d;
    logic             accept;
    logic             hit, min_met, near_limit, tmr_done;
    logic             cnt_load;
    logic [CW-1:0]    cnt_val;

    fpm_delay_cnt #(.CW(CW)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .done(tmr_done)
    );

    fpm_ras_timer #(.LIMIT(T_RASP_MAX), .MIN(T_RAS), .GUARD(GUARD)) u_rtm (
        .clk(clk), .rst_n(rst_n), .ras_low(!dram_ras_n),
        .min_met(min_met), .near_limit(near_limit)
    );

    fpm_row_track #(.ROW_W(ROW_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .open_set(state_q != ST_RAS_ACT && state_d == ST_RAS_ACT),
        .close(state_q != ST_PRECH && state_d == ST_PRECH),
        .open_row(row_q), .req_row(req_row), .hit(hit)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: req_ready = !ref_req;
            ST_OPEN: req_ready = !ref_req && !near_limit && (hit || min_met);
            default: req_ready = 1'b0;
        endcase
    end
    assign accept = req_valid && req_ready;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE:    if (ref_req) state_d = ST_GRANT;
                        else if (accept) state_d = ST_ROW_SET;
            ST_ROW_SET: state_d = ST_RAS_ACT;
            ST_RAS_ACT: if (tmr_done) state_d = ST_COL_SET;
            ST_COL_SET: state_d = ST_CAS_LO;
            ST_CAS_LO:  if (tmr_done) state_d = ST_OPEN;
            ST_OPEN: begin
                if (ref_req || near_limit) begin
                    if (min_met) state_d = ST_PRECH;
                end else if (accept) begin
                    if (hit) state_d = ST_COL_SET;
                    else begin
                        state_d = ST_PRECH;
                        pend_d  = 1'b1;
                    end
                end
            end
            ST_PRECH:   if (tmr_done) begin
                            state_d = pend_q ? ST_ROW_SET : ST_IDLE;
                            pend_d  = 1'b0;
                        end
            ST_GRANT:   if (!ref_req) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        row_d = accept ? req_row   : row_q;
        col_d = accept ? req_col   : col_q;
        wr_d  = accept ? req_write : wr_q;
        wd_d  = accept ? req_wdata : wd_q;
        cnt_load = (state_d != state_q) &&
                   (state_d == ST_RAS_ACT || state_d == ST_CAS_LO || state_d == ST_PRECH);
        unique case (state_d)
            ST_RAS_ACT: cnt_val = CW'(T_RAH - 1);
            ST_CAS_LO:  cnt_val = CW'(T_CAS - 1);
            default:    cnt_val = CW'(T_RP - 1);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wr_q    <= 1'b0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            row_q   <= row_d;
            col_q   <= col_d;
            wr_q    <= wr_d;
            wd_q    <= wd_d;
        end
    end

    // registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_addr  <= '0;
            dram_dq_o  <= '0;
            dram_dq_oe <= 1'b0;
            ref_gnt    <= 1'b0;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
        end else begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            ref_gnt    <= 1'b0;
            rd_valid   <= 1'b0;
            unique case (state_d)
                ST_ROW_SET: dram_addr <= AW'(row_d);
                ST_RAS_ACT: begin
                    dram_ras_n <= 1'b0;
                    dram_addr  <= AW'(row_d);
                end
                ST_COL_SET, ST_CAS_LO: begin
                    dram_ras_n <= 1'b0;
                    dram_cas_n <= (state_d != ST_CAS_LO);
                    dram_addr  <= AW'(col_d);
                    dram_we_n  <= !wr_d;
                    dram_dq_oe <= wr_d;
                    dram_dq_o  <= wd_d;
                    dram_oe_n  <= wr_d || (state_d != ST_CAS_LO);
                end
                ST_OPEN:    dram_ras_n <= 1'b0;
                ST_GRANT:   ref_gnt    <= 1'b1;
                default:    ;
            endcase
            if (state_q == ST_CAS_LO && tmr_done && !wr_q) begin
                rd_valid <= 1'b1;
                rd_data  <= dram_dq_i;
            end
        end
    end

    // checker state: cycles the row strobe has been high, saturating
    logic [HW-1:0] hi_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  hi_cnt_q <= HW'(T_RP);
        else if (!dram_ras_n)        hi_cnt_q <= '0;
        else if (32'(hi_cnt_q) < T_RP) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    p_row_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr));
    p_col_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));
    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n));
    p_bus_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> (dram_oe_n && !dram_we_n));
    p_cas_in_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);
    p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> (32'(hi_cnt_q) >= T_RP));
    p_gnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && dram_cas_n && !req_ready));
endmodule

// File: tb/sim_fpm_ctrl.sv
module sim_fpm_ctrl;
    localparam int ROW_W = 12, COL_W = 10, DQ_W = 4;
    localparam int T_RP = 4, T_RAH = 1, T_CAS = 2, T_RAS = 8, T_RASP = 40;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [DQ_W-1:0]  req_wdata = '0;
    logic             req_ready, rd_valid, ref_gnt;
    logic [DQ_W-1:0]  rd_data, dq_o, dq_i;
    logic             ras_n, cas_n, we_n, oe_n, dq_oe;
    logic [AW-1:0]    addr;

    fpm_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .T_RP(T_RP), .T_RAH(T_RAH),
               .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RASP_MAX(T_RASP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
        .dram_addr(addr), .dram_dq_o(dq_o), .dram_dq_oe(dq_oe), .dram_dq_i(dq_i)
    );

    int n_tests = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // pin-level memory model and shadow copy for the scoreboard
    logic [DQ_W-1:0] mem [256];
    logic [DQ_W-1:0] shadow [256];
    logic [AW-1:0]   row_l = '0, col_l = '0;
    initial for (int i = 0; i < 256; i++) begin mem[i] = '0; shadow[i] = '0; end
    assign dq_i = (!cas_n && !oe_n && we_n) ? mem[{row_l[3:0], col_l[3:0]}] : '0;

    logic [DQ_W-1:0] exp_q [$];

    // monitor: strobe timing, model updates, scoreboard pops
    logic    p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_gnt = 1'b0, cas_seen = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int hi_run = 100, lo_run = 0, cas_hi = 0, cas_lo = 0, cas_len = 0, ras_falls = 0;
    always @(negedge clk) if (rst_n) begin
        if (p_ras && !ras_n) begin
            chk(addr == p_addr, "R2 row addr stable", int'(addr), int'(p_addr));
            chk(hi_run >= T_RP, "R6 precharge", hi_run, T_RP);
            ras_falls++; row_l = addr; lo_run = 1; cas_seen = 1'b0;
        end else if (!ras_n) lo_run++;
        if (!p_ras && ras_n) begin
            chk(lo_run >= T_RAS, "R8 min active", lo_run, T_RAS);
            chk(lo_run <= T_RASP, "R7 page limit", lo_run, T_RASP);
            hi_run = 1;
        end else if (ras_n) hi_run++;
        if (p_cas && !cas_n) begin
            chk(addr == p_addr, "R2 col addr stable", int'(addr), int'(p_addr));
            chk(!ras_n, "R5 cas inside row", int'(ras_n), 0);
            if (cas_seen) chk(cas_hi >= 2, "R10 cas precharge", cas_hi, 2);
            cas_seen = 1'b1; col_l = addr; cas_lo = 1;
            if (!we_n) begin
                chk(!p_we, "R4 we before cas", int'(p_we), 0);
                chk(dq_oe && oe_n, "R4 drive on write", int'(dq_oe), 1);
                mem[{row_l[3:0], col_l[3:0]}] = dq_o;
            end
        end else if (!cas_n) cas_lo++;
        if (!p_cas && cas_n) begin cas_len = cas_lo; cas_hi = 1; end
        else if (cas_n) cas_hi++;
        if (dq_oe && (we_n || !oe_n)) chk(1'b0, "R4 bus conflict", int'(we_n), 0);
        if (rd_valid) begin
            chk(cas_n && cas_len == T_CAS, "R3 read latency", cas_len, T_CAS);
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read", int'(rd_data), -1);
            else begin
                logic [DQ_W-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R3 read data", int'(rd_data), int'(e));
            end
        end
        if (ref_gnt && !p_gnt) begin
            chk(ras_n && cas_n, "R9 strobes idle at grant", int'(ras_n), 1);
            chk(hi_run >= T_RP, "R9 precharge before grant", hi_run, T_RP);
        end
        p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr; p_gnt = ref_gnt;
    end

    // driver: one request, pushes expected read data
    task automatic issue(input bit wr, input int row, input int col, input int d);
        req_valid = 1'b1; req_write = wr;
        req_row = ROW_W'(row); req_col = COL_W'(col); req_wdata = DQ_W'(d);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        if (wr) shadow[{row[3:0], col[3:0]}] = DQ_W'(d);
        else    exp_q.push_back(shadow[{row[3:0], col[3:0]}]);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n, "R1 strobes high", int'(ras_n & cas_n), 1);
        chk(we_n && oe_n, "R1 we/oe high", int'(we_n & oe_n), 1);
        chk(!dq_oe && !rd_valid && !ref_gnt, "R1 quiet outputs", int'(dq_oe | rd_valid | ref_gnt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 page hits in one row, R3 read back, R4 early writes
        f0 = ras_falls;
        issue(1, 1, 2, 5);
        issue(1, 1, 3, 10);
        issue(0, 1, 2, 0);
        issue(0, 1, 3, 0);
        drain();
        chk(ras_falls - f0 == 1, "R5 one row open for hits", ras_falls - f0, 1);

        // R6/R8 row misses
        f0 = ras_falls;
        issue(1, 2, 1, 9);
        issue(0, 1, 2, 0);
        issue(0, 2, 1, 0);
        drain();
        chk(ras_falls - f0 == 3, "R6 reopen on miss", ras_falls - f0, 3);

        // R7 long same-row burst must be split
        f0 = ras_falls;
        for (int i = 0; i < 14; i++) issue(0, 2, 1, 0);
        drain();
        chk(ras_falls - f0 >= 1, "R7 burst split", ras_falls - f0, 1);

        // R9 refresh while a row may be open
        issue(1, 3, 4, 12);
        ref_req = 1'b1;
        while (!ref_gnt) @(negedge clk);
        f0 = ras_falls;
        req_valid = 1'b1; req_write = 1'b0; req_row = 12'd3; req_col = 10'd4;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(!req_ready, "R9 no accept during grant", int'(req_ready), 0);
        end
        req_valid = 1'b0;
        chk(ras_falls == f0, "R9 no row open during grant", ras_falls - f0, 0);
        ref_req = 1'b0;
        @(negedge clk);
        issue(0, 3, 4, 0);
        drain();

        // R9 same-cycle refresh and request while idle (wait for page close first)
        while (!ras_n) @(negedge clk);
        repeat (T_RP + 2) @(negedge clk);
        ref_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_row = 12'd3; req_col = 10'd4;
        #1;
        chk(!req_ready, "R9 refresh wins tie", int'(req_ready), 0);
        while (!ref_gnt) @(negedge clk);
        f0 = ras_falls;
        repeat (3) @(negedge clk);
        chk(ras_falls == f0, "R9 grant holds row closed", ras_falls - f0, 0);
        req_valid = 1'b0;
        ref_req = 1'b0;
        @(negedge clk);
        issue(0, 3, 4, 0);
        issue(1, 3, 5, 7);
        issue(0, 3, 5, 0);
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule